// File: doc/BRIEF.md
# Incremental Encoder Position Decoder

This block turns the two phase signals and the index pulse of an incremental rotary or linear encoder into a 16-bit position count and a direction flag. Each raw input is first brought into the clock domain and cleaned by a digital glitch filter. The filter accepts a new level only after that level has held for a programmable number of filter ticks. The filtered phases are decoded at either two or four counts per encoder cycle. The count wraps between zero and a programmable maximum. Each wrap in either direction sets a sticky interrupt flag.

The block is configured through a simple register write port with a write enable, a 2-bit address and 16 bits of write data. Address 0 is the control word. Address 1 sets the maximum count. Address 2 loads the position directly. Writing a 1 in bit 0 at address 3 clears the interrupt flag. An alternate mode ignores the encoder and makes the counter a free-running 16-bit timer that counts clock cycles and wraps at the same maximum.

Control word bit fields: bit 0 enables counting. Bit 1 selects four counts per cycle when 1 and two when 0. Bit 2 selects timer mode. Bit 3 inverts the direction sense. Bit 4 enables the index pulse. Bits 7:5 hold the filter length select S, which gives a length of N = 2^S ticks. Bits 11:8 hold the tick divider D, which gives one filter tick every D+1 clocks.

Top module: `quad_pos_decoder`

## Requirements
- R1: After reset the position is 0, the direction flag is 0, the interrupt flag is 0, the control word is 0 and the maximum count is 0xFFFF.
- R2: In four-count mode (control bit 1 = 1), every accepted edge of either phase changes the position by exactly one.
- R3: In two-count mode (control bit 1 = 0), only edges of phase A change the position, and edges of phase B leave it unchanged.
- R4: The count goes up, and the direction flag reads 1, when A leads B, which is the sequence AB = 00, 10, 11, 01. The reverse sequence counts down and gives a direction flag of 0. The direction flag updates on every counted event.
- R5: When control bit 3 is 1, the direction sense in R4 is inverted.
- R6: Counting up from the maximum count gives 0 and sets the interrupt flag.
- R7: Counting down from 0 loads the maximum count and sets the interrupt flag. The flag stays set until a write to address 3 with bit 0 = 1.
- R8: When control bit 4 is 1, a rising edge of the filtered index input sets the position to 0 if the direction flag is 1, and to the maximum count if the direction flag is 0. When control bit 4 is 0, the index input has no effect.
- R9: A phase pulse that lasts fewer than N filter ticks is discarded. A level that holds for at least N ticks is accepted. The filter output changes only on a tick.
- R10: In timer mode (control bits 2 and 0 both 1), the position increases by one on every clock. Encoder inputs are ignored. The wrap rule of R6 applies.
- R11: While control bit 0 is 0, the position changes only through a direct write to address 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| enc_idx | input | 1 | Raw encoder index pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| pos_o | output | 16 | Position count |
| dir_o | output | 1 | Direction of the last counted event (1 = up) |
| irq_o | output | 1 | Sticky wrap interrupt flag |

## Verification
A wrong filter counter shows up at the ports as a lost or extra count. With a one-tick filter, that count appears four clocks after the phase input moves. A wrong decoder state shows as a count of the wrong sign or a missing count on the very next edge. The direction flag exposes the sign at once. A wrong wrap comparison shows one clock after the boundary step as a position other than 0 or the maximum, or as an interrupt flag that is missing or set when it should not be. Timer mode makes any slip in the counter visible as an exact cycle count that does not match.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
    localparam int unsigned FSEL_W = 3;
    localparam int unsigned DIV_W  = 4;
    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_MAX    = 1;
    localparam int unsigned ADDR_POS    = 2;
    localparam int unsigned ADDR_IRQCLR = 3;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FSEL_W-1:0] fsel;
        logic              idx_en;
        logic              swap;
        logic              timer;
        logic              x4;
        logic              en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/qpd_filter.sv
module qpd_filter #(
    parameter int unsigned FSELW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [FSELW-1:0] fsel,
    input  logic             din,
    output logic             dout
);
    localparam int unsigned CNTW = (1 << FSELW);

    typedef struct packed {
        logic [1:0]      sync;
        logic            out;
        logic [CNTW-1:0] cnt;
    } flt_t;

    flt_t q, d;
    logic [CNTW-1:0] need;
    logic [CNTW-1:0] cnt_inc;

    always_comb begin
        need    = CNTW'(1) << fsel;
        cnt_inc = q.cnt + CNTW'(1);
        d       = q;
        d.sync  = {q.sync[0], din};
        if (tick) begin
            if (q.sync[1] != q.out) begin
                if (cnt_inc >= need) begin
                    d.out = q.sync[1];
                    d.cnt = '0;
                end else begin
                    d.cnt = cnt_inc;
                end
            end else begin
                d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = q.out;

    assert_filt_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (dout == $past(dout)));
endmodule

// File: rtl/qpd_decode.sv
module qpd_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    input  logic idx,
    input  logic x4,
    input  logic swap,
    output logic ev,
    output logic up,
    output logic idx_rise
);
    typedef struct packed {
        logic a;
        logic b;
        logic i;
    } prev_t;

    prev_t q, d;
    logic ea, eb;

    always_comb begin
        d        = '{a: a, b: b, i: idx};
        ea       = a ^ q.a;
        eb       = b ^ q.b;
        ev       = x4 ? (ea ^ eb) : (ea & ~eb);
        up       = a ^ q.b ^ swap;
        idx_rise = idx & ~q.i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_x2_a_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!x4 && ev) |-> (a != q.a && b == q.b));
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
    import qpd_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_a,
    input  logic          enc_b,
    input  logic          enc_idx,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] pos_o,
    output logic          dir_o,
    output logic          irq_o
);
    localparam int unsigned NIN = 3;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CW-1:0]    pos;
        logic [CW-1:0]    max;
        logic             dir;
        logic             irq;
        logic [DIV_W-1:0] divcnt;
    } st_t;

    st_t q, d;
    logic           tick;
    logic [NIN-1:0] raw, filt;
    logic           dec_ev, dec_up, dec_idx;
    logic           ev, up, idx_hit;
    logic           wr_ctrl, wr_max, wr_pos, wr_clr;
    logic           set_irq;

    assign tick = (q.divcnt == q.ctrl.div);
    assign raw  = {enc_idx, enc_b, enc_a};

    generate
        for (genvar gi = 0; gi < NIN; gi++) begin : g_flt
            qpd_filter #(.FSELW(FSEL_W)) u_flt (
                .clk  (clk),
                .rst_n(rst_n),
                .tick (tick),
                .fsel (q.ctrl.fsel),
                .din  (raw[gi]),
                .dout (filt[gi])
            );
        end
    endgenerate

    qpd_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .a       (filt[0]),
        .b       (filt[1]),
        .idx     (filt[2]),
        .x4      (q.ctrl.x4),
        .swap    (q.ctrl.swap),
        .ev      (dec_ev),
        .up      (dec_up),
        .idx_rise(dec_idx)
    );

    always_comb begin
        wr_ctrl = cfg_we && (cfg_addr == 2'(ADDR_CTRL));
        wr_max  = cfg_we && (cfg_addr == 2'(ADDR_MAX));
        wr_pos  = cfg_we && (cfg_addr == 2'(ADDR_POS));
        wr_clr  = cfg_we && (cfg_addr == 2'(ADDR_IRQCLR)) && cfg_wdata[0];

        ev      = 1'b0;
        up      = 1'b0;
        if (q.ctrl.en) begin
            if (q.ctrl.timer) begin
                ev = 1'b1;
                up = 1'b1;
            end else begin
                ev = dec_ev;
                up = dec_up;
            end
        end
        idx_hit = q.ctrl.en && !q.ctrl.timer && q.ctrl.idx_en && dec_idx;

        d        = q;
        set_irq  = 1'b0;
        d.divcnt = tick ? '0 : q.divcnt + DIV_W'(1);

        if (idx_hit) begin
            d.pos = q.dir ? '0 : q.max;
        end else if (ev) begin
            d.dir = up;
            if (up) begin
                if (q.pos == q.max) begin
                    d.pos   = '0;
                    set_irq = 1'b1;
                end else begin
                    d.pos = q.pos + CW'(1);
                end
            end else begin
                if (q.pos == '0) begin
                    d.pos   = q.max;
                    set_irq = 1'b1;
                end else begin
                    d.pos = q.pos - CW'(1);
                end
            end
        end

        if (wr_ctrl) d.ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        if (wr_max)  d.max  = cfg_wdata;
        if (wr_pos)  d.pos  = cfg_wdata;
        if (set_irq)     d.irq = 1'b1;
        else if (wr_clr) d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.max   <= '1;
        end else begin
            q <= d;
        end
    end

    assign pos_o = q.pos;
    assign dir_o = q.dir;
    assign irq_o = q.irq;

    assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && up && !idx_hit && !wr_pos && q.pos == q.max) |=> (pos_o == '0 && irq_o));

    assert_wrap_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !up && !idx_hit && !wr_pos && q.pos == '0) |=> (pos_o == $past(q.max) && irq_o));

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_clr) |=> irq_o);

    assert_timer_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.en && q.ctrl.timer && !wr_pos && q.pos != q.max) |=> (pos_o == $past(pos_o) + CW'(1)));

    assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctrl.en && !wr_pos) |=> (pos_o == $past(pos_o)));
endmodule

// File: tb/sim_quad_pos_decoder.sv
module sim_quad_pos_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] pos_o;
    logic        dir_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          s_ph = 0;
    int          settle_n = 10;
    bit          m_en = 0, m_x4 = 0, m_swap = 0, m_ie = 0;
    logic [15:0] m_pos = 0, m_max = 16'hFFFF;
    logic        m_dir = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_pos_decoder u0 (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pos_o(pos_o), .dir_o(dir_o), .irq_o(irq_o)
    );

    function automatic logic [15:0] cw(bit en, bit x4, bit tm, bit sw, bit ie,
                                       logic [2:0] fs, logic [3:0] dv);
        return {4'b0, dv, fs, ie, sw, tm, x4, en};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] ad, logic [15:0] dt);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = dt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (settle_n) @(negedge clk);
    endtask

    task automatic model_step(bit upd);
        m_dir = upd;
        if (upd) begin
            if (m_pos == m_max) begin m_pos = 0; m_irq = 1; end
            else m_pos = m_pos + 1;
        end else begin
            if (m_pos == 0) begin m_pos = m_max; m_irq = 1; end
            else m_pos = m_pos - 1;
        end
    endtask

    task automatic mv(bit fw, string tag);
        logic old_a;
        old_a = (s_ph == 1 || s_ph == 2);
        s_ph  = fw ? (s_ph + 1) % 4 : (s_ph + 3) % 4;
        enc_a = (s_ph == 1 || s_ph == 2);
        enc_b = (s_ph == 2 || s_ph == 3);
        if (m_en && (m_x4 || enc_a != old_a)) model_step(fw ^ m_swap);
        settle();
        chk({tag, " pos"}, pos_o, m_pos);
        chk({tag, " dir"}, {15'b0, dir_o}, {15'b0, m_dir});
        chk({tag, " irq"}, {15'b0, irq_o}, {15'b0, m_irq});
    endtask

    task automatic pulse_idx(string tag);
        enc_idx = 1'b1; settle();
        if (m_en && m_ie) m_pos = m_dir ? 16'd0 : m_max;
        enc_idx = 1'b0; settle();
        chk(tag, pos_o, m_pos);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pos", pos_o, 16'd0);
        chk("R1 dir", {15'b0, dir_o}, 16'd0);
        chk("R1 irq", {15'b0, irq_o}, 16'd0);
        // R1 max reset value: counting down from 0 must load 0xFFFF
        wr(2'd0, cw(1,1,0,0,0,0,0)); m_en = 1; m_x4 = 1;
        mv(0, "R1 max reset 0xFFFF / R7");
        wr(2'd3, 16'd1); m_irq = 0;
        wr(2'd2, 16'd0); m_pos = 0;

        for (int i = 0; i < 16; i++) mv(1, "R2 x4 fwd");
        for (int i = 0; i < 16; i++) mv(0, "R4 x4 rev");

        wr(2'd0, cw(1,0,0,0,0,0,0)); m_x4 = 0;
        for (int i = 0; i < 8; i++) mv(1, "R3 x2 fwd");
        for (int i = 0; i < 8; i++) mv(0, "R3 x2 rev");

        wr(2'd0, cw(1,1,0,1,0,0,0)); m_x4 = 1; m_swap = 1;
        for (int i = 0; i < 4; i++) mv(1, "R5 swap");
        wr(2'd3, 16'd1); m_irq = 0;
        chk("R7 irq clear", {15'b0, irq_o}, 16'd0);

        wr(2'd0, cw(1,1,0,0,0,0,0)); m_swap = 0;
        wr(2'd1, 16'd5); m_max = 5;
        wr(2'd2, 16'd4); m_pos = 4;
        for (int i = 0; i < 3; i++) mv(1, "R6 wrap up");
        chk("R6 irq set", {15'b0, irq_o}, 16'd1);
        wr(2'd3, 16'd1); m_irq = 0;
        wr(2'd2, 16'd1); m_pos = 1;
        for (int i = 0; i < 3; i++) mv(0, "R7 wrap down");
        chk("R7 irq set", {15'b0, irq_o}, 16'd1);
        wr(2'd3, 16'd0);
        chk("R7 irq held on bit0=0", {15'b0, irq_o}, 16'd1);
        wr(2'd3, 16'd1); m_irq = 0;

        wr(2'd0, cw(1,1,0,0,1,0,0)); m_ie = 1;
        wr(2'd2, 16'd2); m_pos = 2;
        mv(1, "R8 pre up");
        pulse_idx("R8 index up -> 0");
        mv(1, "R8 pre up2");
        mv(0, "R8 pre down");
        pulse_idx("R8 index down -> max");
        wr(2'd0, cw(1,1,0,0,0,0,0)); m_ie = 0;
        mv(0, "R8 pre disabled");
        pulse_idx("R8 index disabled");

        wr(2'd0, cw(0,1,0,0,0,0,0)); m_en = 0;
        for (int i = 0; i < 4; i++) mv(1, "R11 disabled");
        wr(2'd2, 16'd3); m_pos = 3;
        settle();
        chk("R11 direct write", pos_o, 16'd3);

        wr(2'd0, cw(1,1,0,0,0,3'd3,0)); m_en = 1;
        settle_n = 30;
        enc_a = ~enc_a;
        repeat (4) @(negedge clk);
        enc_a = ~enc_a;
        settle();
        chk("R9 short glitch discarded", pos_o, m_pos);
        mv(1, "R9 long level accepted");
        mv(1, "R9 long level accepted 2");
        settle_n = 10;

        wr(2'd0, 16'd0); m_en = 0;
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd1);
        wr(2'd0, cw(1,1,1,0,0,0,0));
        repeat (20) @(negedge clk);
        wr(2'd0, 16'd0);
        chk("R10 timer count", pos_o, 16'd21);
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd0);
        wr(2'd0, cw(1,1,1,0,0,0,0));
        enc_a = ~enc_a;
        repeat (24) @(negedge clk);
        wr(2'd0, 16'd0);
        chk("R10 timer wrap pos", pos_o, 16'd5);
        chk("R10 timer wrap irq", {15'b0, irq_o}, 16'd1);

        done = 1;
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
            wait (done);
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule